// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block catches software that has stopped running as intended. A down counter counts prescaled clock ticks. When it runs past zero, the block raises an interrupt request. Software that is still healthy sends a refresh strobe often enough that the counter never gets that far.

The tick rate is set by two dividers in series:
- A system divider turns the CPU clock into an internal clock. It divides by 1, 2, 4, 8 or 16, chosen by three clock-control bits.
- A prescaler then divides that internal clock by a small or a large ratio. The ratio is chosen by one bit of a byte-wide control register, written through a simple register write port.

A refresh reloads the counter but leaves the prescaler phase alone. Because of this, the real timeout after a refresh can be up to one prescaler period shorter than the nominal one.

Top module: `watchdog_timer`

## Requirements
- R1: After reset, `wdIrq` is 0, the counter holds its all-ones maximum, both divider phases are cleared, and the ratio select is 0 (small ratio).
- R2: With `clkSel8`=0, `clkDivCode` values 0, 1, 2 and 3 make the system divider divide the clock by 1, 2, 4 and 16 respectively. With code 0, a system tick occurs on every cycle.
- R3: With `clkSel8`=1, the system divider divides by 8 whatever `clkDivCode` holds.
- R4: A write with `wrAddr` = `CTL_ADDR` (0x0F) stores bit 7 of `wrData` as the ratio select: 0 selects divide by `PRE_LO` (16) and 1 selects divide by `PRE_HI` (128). Writes to any other address leave the ratio unchanged.
- R5: Each prescaled tick decrements the counter by one. Without a refresh, the interrupt occurs every D·P·2^`CNT_W` clocks, where D is the system divide and P is the prescaler ratio. The first interrupt after reset comes D·P·2^`CNT_W` clock edges after reset is released.
- R6: The interrupt request is a one-clock pulse. When it fires, the counter wraps to its maximum and carries on, so the next pulse follows one full period later.
- R7: A refresh reloads the counter to its maximum without touching the prescaler phase.
  - A refresh wins over a coinciding tick: there is no decrement and no interrupt.
  - After a refresh on edge r, the interrupt comes 2^`CNT_W` ticks later, where the first of those ticks is the first tick edge after r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkSel8 | input | 1 | Forces the system divide to 8 |
| clkDivCode | input | 2 | System divide code used when `clkSel8` is 0 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register byte address |
| wrData | input | 8 | Register write data |
| refresh | input | 1 | Software refresh strobe |
| wdIrq | output | 1 | Watchdog interrupt request pulse |

## Verification
The hardest case to reach from the ports is a refresh that lands exactly on a prescaled tick edge. The only way to tell that the refresh won is by the interrupt time, which must fall one whole prescaler period later than for a refresh landing between ticks. The bench gets there by releasing reset at a known cycle, because the prescaler phase is fixed from that moment. It then fires a refresh once on a tick edge and once off a tick edge, and compares both interrupt times against a closed-form schedule. A short counter width is used so that every divide and ratio pairing reaches its interrupt twice within the run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic tick;     // one prescaled tick this cycle
    logic refresh;  // software reload request this cycle
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int PRE_LO   = 16,
  parameter int PRE_HI   = 128,
  parameter int CTL_ADDR = 15,
  parameter int RATIO_BIT = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkSel8,
  input  logic [1:0] clkDivCode,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       refresh,
  output wdtStrobe_t strobe
);
  localparam int DIV_MAX = 16;
  localparam int DIV_W   = $clog2(DIV_MAX);
  localparam int PRE_W   = $clog2(PRE_HI);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;
  logic             ratioSel;
  logic             sysTick;
  logic             preTick;

  always_comb begin
    if (clkSel8) divLast = DIV_W'(7);
    else begin
      case (clkDivCode)
        2'd0:    divLast = DIV_W'(0);
        2'd1:    divLast = DIV_W'(1);
        2'd2:    divLast = DIV_W'(3);
        default: divLast = DIV_W'(DIV_MAX - 1);
      endcase
    end
  end

  assign sysTick = (divCnt >= divLast);
  assign preLast = ratioSel ? PRE_W'(PRE_HI - 1) : PRE_W'(PRE_LO - 1);
  assign preTick = sysTick && (preCnt >= preLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (sysTick) divCnt <= '0;
    else divCnt <= divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (preTick) preCnt <= '0;
    else if (sysTick) preCnt <= preCnt + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ratioSel <= 1'b0;
    else if (wrEn && wrAddr == 8'(CTL_ADDR)) ratioSel <= wrData[RATIO_BIT];
  end

  assign strobe.tick    = preTick;
  assign strobe.refresh = refresh;

  assert_div1_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!clkSel8 && clkDivCode == 2'd0) |-> sysTick);
  assert_div8_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel8 && $past(clkSel8) && sysTick) |=> !sysTick);
  assert_ratio_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != 8'(CTL_ADDR)) |=> $stable(ratioSel));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtStrobe_t strobe,
  output logic       wdIrq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= CNT_MAX;
      wdIrq <= 1'b0;
    end else begin
      wdIrq <= 1'b0;
      if (strobe.refresh) cnt <= CNT_MAX;
      else if (strobe.tick) begin
        if (cnt == '0) begin
          cnt   <= CNT_MAX;
          wdIrq <= 1'b1;
        end else cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assert_dec_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.refresh && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    wdIrq |=> !wdIrq);
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    wdIrq |-> (cnt == CNT_MAX));
  assert_refresh_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.refresh |=> (cnt == CNT_MAX && !wdIrq));
endmodule

// File: rtl/watchdog_timer.sv
module watchdog_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int PRE_LO   = 16,
  parameter int PRE_HI   = 128,
  parameter int CTL_ADDR = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkSel8,
  input  logic [1:0] clkDivCode,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       refresh,
  output logic       wdIrq
);
  wdtStrobe_t strobe;

  wdt_ctrl #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .CTL_ADDR(CTL_ADDR), .RATIO_BIT(7)) ctrl_i (
    .clk(clk), .rstN(rstN), .clkSel8(clkSel8), .clkDivCode(clkDivCode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .refresh(refresh), .strobe(strobe)
  );

  wdt_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdIrq(wdIrq)
  );
endmodule

// File: tb/watchdog_timer_tb_top.sv
module watchdog_timer_tb_top;
  localparam int W = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkSel8 = 1'b0;
  logic [1:0] clkDivCode = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = 8'd0;
  logic [7:0] wrData = 8'd0;
  logic       refresh = 1'b0;
  logic       wdIrq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int expQ[$];
  logic prevIrq = 1'b0;
  string curReq = "R5";

  always #2 clk = ~clk;  // 250 MHz

  watchdog_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .clkSel8(clkSel8), .clkDivCode(clkDivCode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .refresh(refresh), .wdIrq(wdIrq)
  );

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // Monitor: pops expected interrupt cycles and compares (R5, R6, R7)
  always @(negedge clk) begin
    if (rstN && wdIrq) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected irq: actual cycle %0d expected none", curReq, cyc);
      end else begin
        int e;
        e = expQ.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL %s irq time: actual %0d expected %0d", curReq, cyc, e);
        end
      end
      if (prevIrq) begin
        fails++;
        $display("FAIL R6 pulse width: actual 2+ cycles expected 1");
      end
    end
    prevIrq = rstN && wdIrq;
  end

  task automatic runScenario(input string req, input logic sel8, input logic [1:0] code,
                             input logic doWr, input logic [7:0] addr, input int d, input int p,
                             input int refAt);
    int per;
    int first;
    int last;
    curReq = req;
    per = d * p * (1 << W);
    @(negedge clk);
    rstN = 1'b0;
    clkSel8 = sel8;
    clkDivCode = code;
    expQ.delete();
    repeat (3) @(negedge clk);
    checks++;
    if (wdIrq !== 1'b0) begin
      fails++;
      $display("FAIL R1 irq in reset: actual %b expected 0", wdIrq);
    end
    if (refAt > 0) first = ((refAt + 1 + d * p - 1) / (d * p)) * (d * p) + ((1 << W) - 1) * d * p;
    else first = per;
    expQ.push_back(first);
    expQ.push_back(first + per);
    last = first + per;
    rstN = 1'b1;
    wrEn = doWr;
    wrAddr = addr;
    wrData = 8'h80;
    @(negedge clk);
    wrEn = 1'b0;
    if (refAt > 0) begin
      while (cyc < refAt - 1) @(negedge clk);
      refresh = 1'b1;
      @(negedge clk);
      refresh = 1'b0;
    end
    while (cyc < last + 4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL %s missing irq: actual %0d pending expected 0", req, expQ.size());
    end
  endtask

  initial begin
    runScenario("R1_R2_R5_R6", 1'b0, 2'd0, 1'b0, 8'h0F, 1, 16, 0);   // reset ratio 16, div 1
    runScenario("R2_R4", 1'b0, 2'd1, 1'b1, 8'h0F, 2, 128, 0);         // div 2, ratio 128
    runScenario("R4", 1'b0, 2'd2, 1'b1, 8'h0E, 4, 16, 0);             // other address ignored
    runScenario("R2", 1'b0, 2'd3, 1'b0, 8'h0F, 16, 16, 0);            // div 16
    runScenario("R3", 1'b1, 2'd3, 1'b0, 8'h0F, 8, 16, 0);             // div 8, code ignored
    runScenario("R3_R4", 1'b1, 2'd0, 1'b1, 8'h0F, 8, 128, 0);         // div 8, ratio 128
    runScenario("R7", 1'b0, 2'd0, 1'b0, 8'h0F, 1, 16, 100);           // refresh between ticks
    runScenario("R7", 1'b0, 2'd0, 1'b0, 8'h0F, 1, 16, 112);           // refresh on a tick edge
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule